// File: doc/BRIEF.md
# Multi-Mode LCD Panel Scan Timing Generator

This block produces every scan control pulse needed by a small active-matrix panel whose horizontal and vertical shift registers can run in either direction. A pixel-rate clock drives it. An external line strobe and frame strobe set the raster, and the generator turns them into a horizontal start pulse, a pair of complementary horizontal shift clocks, a vertical start pulse, a vertical shift clock, a gate enable, a precharge pulse, a black-border pulse and a per-line video polarity flag.

A 3-bit geometry code chooses how many lines are scanned per frame and how many horizontal clock periods are produced per line. Because each geometry has its own counts, a smaller picture stays centred on the panel, with black borders around it. Two direction inputs choose right or left scan and down or up scan. Each one moves the start pulse by half a shift-clock period relative to that clock. The geometry code and the direction inputs are captured only at the frame strobe, so every frame uses a single set of parameters from start to end.

All horizontal timing is counted in pixel clocks from the line strobe. The vertical timing is counted in lines from the frame strobe.

Top module: `lcd_scan_timing`

## Requirements
- R1: Within one frame, `vck` toggles once at the start of each active line. The number of active lines is the geometry's base count shifted right by `LINE_SHIFT`. The base counts are: code 000 gives 624, 001 gives 600, 010 gives 572, 011 gives 480, 100 gives 400, 101 gives 480. Active lines are frame lines V_START+1 through V_START+count, where V_START = BLK_LINES+1 and the first line after the frame strobe is line 0.
- R2: On every active line, `hck1` rises exactly N times. N is 140 for codes 000 and 101, 134 for code 001, 128 for code 010, and 108 for codes 011 and 100. On all other lines `hck1` stays low.
- R3: `hck2` is always the complement of `hck1`. On an active line, shift-clock period p starts H_LEAD + 2·p·HCK_HALF pixel clocks after the line strobe, with `hck1` high for its first HCK_HALF clocks and low for its second HCK_HALF clocks.
- R4: On an active line, `hst` is high for exactly 2·HCK_HALF pixel clocks. With `dir_right`=1 it rises together with the first rising edge of `hck1`. With `dir_right`=0 it rises HCK_HALF clocks earlier, on the preceding rising edge of `hck2`.
- R5: Each frame, `vst` is high for exactly two lines, which is one `vck` period. With `dir_down`=1 it rises at line V_START+1, together with the first `vck` edge. With `dir_down`=0 it rises one line earlier.
- R6: `gate_en` is high while the shift clocks run and falls when the last period ends. The line precharge pulse then starts PCG_GAP clocks later and lasts PCG_WIDTH clocks.
- R7: `prechg` equals the line precharge pulse ORed with `blank_pulse`.
- R8: `blank_pulse` is high during frame lines 0 to BLK_LINES−1 for codes 001 to 101. For code 000 it stays low. `vst` never rises while `blank_pulse` is high.
- R9: `vid_pol` resets to 0 and inverts at every line strobe.
- R10: Changes on `mode_code`, `dir_right` and `dir_down` between frame strobes have no effect on the current frame.
- R11: When the frame strobe and the line strobe arrive in the same cycle, that line is line 0 of the new frame and already uses the new geometry.
- R12: After reset, every output is low except `hck2`, which is high.
- R13: The unused codes 110 and 111 behave exactly like code 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_sync | input | 1 | One-cycle line start strobe |
| frame_sync | input | 1 | One-cycle frame start strobe; captures geometry and directions |
| mode_code | input | 3 | Geometry select |
| dir_right | input | 1 | 1 = right scan, 0 = left scan |
| dir_down | input | 1 | 1 = down scan, 0 = up scan |
| hst | output | 1 | Horizontal start pulse |
| hck1 | output | 1 | Horizontal shift clock, phase 1 |
| hck2 | output | 1 | Horizontal shift clock, phase 2 |
| vst | output | 1 | Vertical start pulse |
| vck | output | 1 | Vertical shift clock |
| gate_en | output | 1 | Gate enable for the selected row |
| prechg | output | 1 | Precharge pulse (line pulse OR black border) |
| blank_pulse | output | 1 | Black-border pulse |
| vid_pol | output | 1 | Video polarity flag for the current line |

## Verification
The frame strobe and the line strobe can land on the same clock edge. When they do, the line counter has to restart at zero and use the newly captured geometry, instead of advancing the old frame. The bench provokes this by issuing one frame with both strobes in a single cycle. It then judges that frame exactly as it judges any other: the number of `vck` toggles, the line on which `vst` rises, the number of black-border lines, and the pixel-exact pattern of every line. Throughout each frame the bench scrambles the geometry and direction pins, so that any sampling outside the frame strobe shows up as wrong counts.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int LINES_W = 10;
  localparam int HCKS_W  = 8;

  typedef struct packed {
    logic [LINES_W-1:0] lines;
    logic [HCKS_W-1:0]  hcks;
    logic               blank_en;
    logic               right;
    logic               down;
  } scan_cfg_t;

  // Full-size vertical line count per geometry code (unused codes fall back to 000)
  function automatic logic [LINES_W-1:0] base_lines(input logic [2:0] code);
    case (code)
      3'b001:         return 10'd600;
      3'b010:         return 10'd572;
      3'b011, 3'b101: return 10'd480;
      3'b100:         return 10'd400;
      default:        return 10'd624;
    endcase
  endfunction

  // Horizontal shift-clock periods per line
  function automatic logic [HCKS_W-1:0] hck_periods(input logic [2:0] code);
    case (code)
      3'b001:         return 8'd134;
      3'b010:         return 8'd128;
      3'b011, 3'b100: return 8'd108;
      default:        return 8'd140;
    endcase
  endfunction

  // Black border exists in every geometry smaller than the full panel
  function automatic logic border_needed(input logic [2:0] code);
    return (code >= 3'b001) && (code <= 3'b101);
  endfunction

  function automatic scan_cfg_t decode_cfg(input logic [2:0] code, input logic right,
                                           input logic down, input int shift);
    scan_cfg_t c;
    c.lines    = base_lines(code) >> shift;
    c.hcks     = hck_periods(code);
    c.blank_en = border_needed(code);
    c.right    = right;
    c.down     = down;
    return c;
  endfunction

  // Line index i (0 = first line after frame strobe) carries a vck edge
  function automatic logic line_in_active(input int i, input int vstart, input int lines);
    return (i >= vstart + 1) && (i <= vstart + lines);
  endfunction

  // Lines on which the vertical start pulse is held
  function automatic logic vst_line(input int i, input int vstart, input logic down);
    if (down) return (i == vstart + 1) || (i == vstart + 2);
    return (i == vstart) || (i == vstart + 1);
  endfunction

  // Pixel position t lies in window [lo, lo+len)
  function automatic logic in_window(input int t, input int lo, input int len);
    return (t >= lo) && (t < lo + len);
  endfunction

endpackage

// File: rtl/lcd_mode_latch.sv
module lcd_mode_latch #(
  parameter int LINE_SHIFT = 0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              frame_sync,
  input  logic [2:0]                        mode_code,
  input  logic                              dir_right,
  input  logic                              dir_down,
  output logic [lcd_scan_pkg::HCKS_W-1:0]   q_hcks,
  output logic                              q_right,
  output logic [lcd_scan_pkg::LINES_W-1:0]  e_lines,
  output logic                              e_blank_en,
  output logic                              e_down
);
  import lcd_scan_pkg::*;

  scan_cfg_t cfg_q;
  scan_cfg_t cfg_pin;
  scan_cfg_t cfg_eff;

  assign cfg_pin = decode_cfg(mode_code, dir_right, dir_down, LINE_SHIFT);
  // the frame strobe cycle already sees the new geometry (line 0 may start there)
  assign cfg_eff = frame_sync ? cfg_pin : cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cfg_q <= decode_cfg(3'b000, 1'b1, 1'b1, LINE_SHIFT);
    else if (frame_sync) cfg_q <= cfg_pin;
  end

  assign q_hcks     = cfg_q.hcks;
  assign q_right    = cfg_q.right;
  assign e_lines    = cfg_eff.lines;
  assign e_blank_en = cfg_eff.blank_en;
  assign e_down     = cfg_eff.down;

  // R10: captured parameters move only at a frame strobe
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(cfg_q));

endmodule

// File: rtl/lcd_vscan.sv
module lcd_vscan #(
  parameter int BLK_LINES = 2,
  parameter int LINE_W    = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              line_sync,
  input  logic                              frame_sync,
  input  logic [lcd_scan_pkg::LINES_W-1:0]  lines,
  input  logic                              blank_en,
  input  logic                              down,
  output logic                              vck,
  output logic                              vst,
  output logic                              blank,
  output logic                              line_act,
  output logic                              vid_pol
);
  import lcd_scan_pkg::*;

  localparam int V_START = BLK_LINES + 1;
  localparam logic [LINE_W-1:0] CNT_MAX = '1;

  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] idx;
  logic act_nxt, vst_nxt, blank_nxt;

  always_comb begin
    idx       = frame_sync ? '0 : line_cnt;
    act_nxt   = line_in_active(int'(idx), V_START, int'(lines));
    vst_nxt   = vst_line(int'(idx), V_START, down);
    blank_nxt = blank_en && (int'(idx) < BLK_LINES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= CNT_MAX;
      line_act <= 1'b0;
      vst      <= 1'b0;
      vck      <= 1'b0;
      blank    <= 1'b0;
      vid_pol  <= 1'b0;
    end else if (line_sync) begin
      line_cnt <= (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;
      line_act <= act_nxt;
      vst      <= vst_nxt;
      blank    <= blank_nxt;
      vid_pol  <= ~vid_pol;
      if (act_nxt) vck <= ~vck;
    end else if (frame_sync) begin
      line_cnt <= '0;
    end
  end

  // R9: polarity inverts on every line strobe
  assert_pol_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_sync |=> (vid_pol != $past(vid_pol)));

  // R1: vertical clock edges only at line starts
  assert_vck_at_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_sync |=> $stable(vck));

  // R8: start pulse never rises inside the black border
  assert_vst_after_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vst) |-> !blank);

  // R8: full-panel geometry keeps the border pulse low
  assert_no_blank_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sync && !blank_en) |=> !blank);

endmodule

// File: rtl/lcd_hscan.sv
module lcd_hscan #(
  parameter int HCK_HALF  = 2,
  parameter int H_LEAD    = 8,
  parameter int PCG_GAP   = 4,
  parameter int PCG_WIDTH = 8,
  parameter int PCNT_W    = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             line_sync,
  input  logic                             line_act,
  input  logic [lcd_scan_pkg::HCKS_W-1:0]  hcks,
  input  logic                             right,
  output logic                             hck1,
  output logic                             hck2,
  output logic                             hst,
  output logic                             gate_en,
  output logic                             pcg_line
);
  import lcd_scan_pkg::*;

  localparam logic [PCNT_W-1:0] PMAX = '1;
  // left scan starts half a shift period early; lead must cover it
  localparam int HST_EARLY = (H_LEAD >= HCK_HALF) ? H_LEAD - HCK_HALF : 0;
  localparam int HST_LEN   = 2 * HCK_HALF;

  logic [PCNT_W-1:0] pcnt;
  logic run_nxt, hck_nxt, hst_nxt, pcg_nxt;

  function automatic int run_length(input logic [HCKS_W-1:0] n);
    return 2 * int'(n) * HCK_HALF;
  endfunction

  function automatic logic first_half(input int t);
    return (((t - H_LEAD) / HCK_HALF) % 2) == 0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)              pcnt <= PMAX;
    else if (line_sync)      pcnt <= '0;
    else if (pcnt != PMAX)   pcnt <= pcnt + 1'b1;
  end

  always_comb begin
    int t;
    int rlen;
    t       = int'(pcnt);
    rlen    = run_length(hcks);
    run_nxt = line_act && in_window(t, H_LEAD, rlen);
    hck_nxt = run_nxt && first_half(t);
    hst_nxt = line_act && in_window(t, right ? H_LEAD : HST_EARLY, HST_LEN);
    pcg_nxt = line_act && in_window(t, H_LEAD + rlen + PCG_GAP, PCG_WIDTH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hck1     <= 1'b0;
      hck2     <= 1'b1;
      hst      <= 1'b0;
      gate_en  <= 1'b0;
      pcg_line <= 1'b0;
    end else begin
      hck1     <= hck_nxt;
      hck2     <= ~hck_nxt;
      hst      <= hst_nxt;
      gate_en  <= run_nxt;
      pcg_line <= pcg_nxt;
    end
  end

  // R3: two shift-clock phases never overlap or gap
  assert_hck_compl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hck1 != hck2);

  // R6: precharge starts only once the gate enable has dropped
  assert_pcg_after_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcg_line) |-> !gate_en);

  // R4: start pulse belongs to an active line
  assert_hst_in_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hst |-> line_act);

  // R2: no shift clock on lines outside the picture
  assert_hck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sync && !line_act) |=> ##1 !hck1);

endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
  parameter int LINE_SHIFT = 0,
  parameter int BLK_LINES  = 2,
  parameter int LINE_W     = 10,
  parameter int HCK_HALF   = 2,
  parameter int H_LEAD     = 8,
  parameter int PCG_GAP    = 4,
  parameter int PCG_WIDTH  = 8,
  parameter int PCNT_W     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_sync,
  input  logic       frame_sync,
  input  logic [2:0] mode_code,
  input  logic       dir_right,
  input  logic       dir_down,
  output logic       hst,
  output logic       hck1,
  output logic       hck2,
  output logic       vst,
  output logic       vck,
  output logic       gate_en,
  output logic       prechg,
  output logic       blank_pulse,
  output logic       vid_pol
);
  import lcd_scan_pkg::*;

  logic [HCKS_W-1:0]  q_hcks;
  logic               q_right;
  logic [LINES_W-1:0] e_lines;
  logic               e_blank_en;
  logic               e_down;
  logic               line_act;
  logic               pcg_line;

  lcd_mode_latch #(.LINE_SHIFT(LINE_SHIFT)) u_latch (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .mode_code(mode_code), .dir_right(dir_right), .dir_down(dir_down),
    .q_hcks(q_hcks), .q_right(q_right),
    .e_lines(e_lines), .e_blank_en(e_blank_en), .e_down(e_down)
  );

  lcd_vscan #(.BLK_LINES(BLK_LINES), .LINE_W(LINE_W)) u_vscan (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .frame_sync(frame_sync),
    .lines(e_lines), .blank_en(e_blank_en), .down(e_down),
    .vck(vck), .vst(vst), .blank(blank_pulse), .line_act(line_act), .vid_pol(vid_pol)
  );

  lcd_hscan #(.HCK_HALF(HCK_HALF), .H_LEAD(H_LEAD), .PCG_GAP(PCG_GAP),
              .PCG_WIDTH(PCG_WIDTH), .PCNT_W(PCNT_W)) u_hscan (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .line_act(line_act),
    .hcks(q_hcks), .right(q_right),
    .hck1(hck1), .hck2(hck2), .hst(hst), .gate_en(gate_en), .pcg_line(pcg_line)
  );

  assign prechg = pcg_line | blank_pulse;

  // R7: border pulse always reaches the precharge pin
  assert_blank_to_prechg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blank_pulse |-> prechg);

endmodule

// File: tb/lcd_scan_timing_tb.sv
module lcd_scan_timing_tb;

  localparam int SHIFT = 5;
  localparam int BLK   = 2;
  localparam int HALF  = 1;
  localparam int LEAD  = 4;
  localparam int GAP   = 2;
  localparam int PW    = 4;
  localparam int VS    = BLK + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_sync = 1'b0, frame_sync = 1'b0;
  logic [2:0] mode_code = 3'b000;
  logic dir_right = 1'b1, dir_down = 1'b1;
  logic hst, hck1, hck2, vst, vck, gate_en, prechg, blank_pulse, vid_pol;

  always #4 clk = ~clk;

  lcd_scan_timing #(.LINE_SHIFT(SHIFT), .BLK_LINES(BLK), .HCK_HALF(HALF),
                    .H_LEAD(LEAD), .PCG_GAP(GAP), .PCG_WIDTH(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .frame_sync(frame_sync),
    .mode_code(mode_code), .dir_right(dir_right), .dir_down(dir_down),
    .hst(hst), .hck1(hck1), .hck2(hck2), .vst(vst), .vck(vck), .gate_en(gate_en),
    .prechg(prechg), .blank_pulse(blank_pulse), .vid_pol(vid_pol)
  );

  typedef struct { int hcks; bit right; bit act; bit blank; string note; } line_t;
  typedef struct { int vck; int vst_line; int blank_lines; string note; } frame_t;

  line_t  lq[$];
  frame_t fq[$];
  int n_checks = 0, n_fail = 0;
  bit done = 0, mon_en = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Geometry table restated: sizes per code, unused codes act like full panel (R13)
  function automatic int exp_lines(input int code);
    int tab[8] = '{624, 600, 572, 480, 400, 480, 624, 624};
    return tab[code] >> SHIFT;
  endfunction
  function automatic int exp_hcks(input int code);
    int tab[8] = '{140, 134, 128, 108, 108, 140, 140, 140};
    return tab[code];
  endfunction

  // ---------------- monitor ----------------
  line_t  cur;
  bit line_open = 0, frame_open = 0;
  int k, rises, e_hck, e_cmp, e_hst, e_gate, e_pre, bad_k;
  bit prev_hck1 = 0, prev_vck = 0, prev_vst = 0, prev_pol = 0;
  int vck_tog, vst_rise, vst_lines, blank_lines, line_no;

  task automatic close_line();
    int n = cur.act ? cur.hcks : 0;
    chk(rises == n, "R2", {"hck1 rises ", cur.note}, rises, n);
    chk(e_hck == 0, "R3", "hck1 pattern mismatches", e_hck, 0);
    chk(e_cmp == 0, "R3", "hck2 not complement", e_cmp, 0);
    chk(e_hst == 0, "R4", "hst pattern mismatches", e_hst, 0);
    chk(e_gate == 0, "R6", "gate_en pattern mismatches", e_gate, 0);
    chk(e_pre == 0, "R7", "prechg mismatches, first at k", bad_k, -1);
    void'(lq.pop_front());
  endtask

  task automatic close_frame();
    frame_t f = fq.pop_front();
    chk(vck_tog == f.vck, "R1", {"vck toggles R10 ", f.note}, vck_tog, f.vck);
    chk(vst_rise == f.vst_line, "R5", {"vst rise line ", f.note}, vst_rise, f.vst_line);
    chk(vst_lines == 2, "R5", "vst lines", vst_lines, 2);
    chk(blank_lines == f.blank_lines, "R8", {"blank lines ", f.note}, blank_lines, f.blank_lines);
  endtask

  task automatic sample();
    if (frame_sync) begin
      if (frame_open && fq.size() > 0) close_frame();
      frame_open = 1; vck_tog = 0; vst_rise = -1; vst_lines = 0; blank_lines = 0; line_no = -1;
    end
    if (line_sync) begin
      if (line_open) close_line();
      cur = lq[0];
      line_open = 1; k = 0; rises = 0; e_hck = 0; e_cmp = 0; e_hst = 0; e_gate = 0; e_pre = 0; bad_k = -1;
      line_no++;
      if (vck != prev_vck) vck_tog++;
      if (vst && !prev_vst) vst_rise = line_no;
      if (vst) vst_lines++;
      if (blank_pulse) blank_lines++;
      chk(vid_pol != prev_pol, "R9", "polarity toggle", vid_pol, !prev_pol);
      prev_pol = vid_pol;
    end
    prev_vck = vck; prev_vst = vst;
    if (line_open) begin
      int j = k - 1;
      int r = 2 * cur.hcks * HALF;
      int s = cur.right ? LEAD : LEAD - HALF;
      bit run = cur.act && j >= LEAD && j < LEAD + r;
      bit x_hck = run && ((j - LEAD) % (2 * HALF)) < HALF;
      bit x_hst = cur.act && j >= s && j < s + 2 * HALF;
      bit x_pcg = cur.act && j >= LEAD + r + GAP && j < LEAD + r + GAP + PW;
      bit x_pre = x_pcg || cur.blank;
      if (hck1 != x_hck) e_hck++;
      if (hck2 == hck1) e_cmp++;
      if (hst != x_hst) e_hst++;
      if (gate_en != run) e_gate++;
      if (prechg != x_pre) begin e_pre++; if (bad_k < 0) bad_k = k; end
      if (hck1 && !prev_hck1) rises++;
      k++;
    end
    prev_hck1 = hck1;
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      if (mon_en) sample();
    end
  end

  // ---------------- driver ----------------
  task automatic run_frame(input int code, input bit right, input bit down,
                           input bit joint, input string note);
    int L = exp_lines(code);
    int N = exp_hcks(code);
    int blk = (code >= 1 && code <= 5) ? BLK : 0;
    int P = 2 * N * HALF + LEAD + GAP + PW + 8;
    int nl = VS + L + 2;
    frame_t f;
    f.vck = L; f.vst_line = down ? VS + 1 : VS; f.blank_lines = blk; f.note = note;
    fq.push_back(f);
    @(negedge clk);
    mode_code = code[2:0]; dir_right = right; dir_down = down;
    if (!joint) begin
      frame_sync = 1'b1;
      @(negedge clk);
      frame_sync = 1'b0;
      mode_code = code[2:0] ^ 3'b011; dir_right = !right; dir_down = !down; // R10 scramble
      repeat (2) @(negedge clk);
    end
    for (int li = 0; li < nl; li++) begin
      line_t it;
      it.hcks = N; it.right = right; it.blank = li < blk;
      it.act = (li >= VS + 1) && (li <= VS + L); it.note = note;
      lq.push_back(it);
      line_sync = 1'b1;
      if (joint && li == 0) frame_sync = 1'b1; // R11: both strobes together
      @(negedge clk);
      line_sync = 1'b0; frame_sync = 1'b0;
      if (li == 0) begin
        mode_code = code[2:0] ^ 3'b011; dir_right = !right; dir_down = !down;
      end
      repeat (P - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R12: reset state
    chk(hst == 0 && vst == 0 && vck == 0 && gate_en == 0, "R12", "start/clock/gate low",
        {hst, vst, vck, gate_en}, 0);
    chk(hck1 == 0 && hck2 == 1, "R12", "hck1/hck2 idle", {hck1, hck2}, 1);
    chk(prechg == 0 && blank_pulse == 0 && vid_pol == 0, "R12", "prechg/blank/pol low",
        {prechg, blank_pulse, vid_pol}, 0);
    mon_en = 1;
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 6; c++) begin
        bit r = ((c % 2) == 0) ^ (pass == 1);
        bit d = ((c % 4) < 2) ^ (pass == 1) ^ (c == 2);
        run_frame(c, r, d, 0, "mode frame");
      end
    end
    run_frame(6, 1, 0, 0, "R13 code 110");
    run_frame(7, 0, 1, 0, "R13 code 111");
    run_frame(4, 1, 1, 1, "R11 joint strobes");
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule